// File: doc/BRIEF.md
# Cursor-Addressed Indexed-Pixel Display Port

This block connects a simple register bus to a frame of 8-bit indexed pixels. The frame is 320 columns wide and 240 rows tall, and the pixels live in an external single-port memory. Software never addresses a pixel directly. It loads a row cursor and a column cursor, then reads or writes a data register that reaches the pixel under the cursor. A fourth register has no storage. Writing to it raises a one-cycle refresh pulse toward the display side.

Pixel writes and all non-pixel accesses complete in the cycle they are presented. A pixel read costs one extra cycle of memory latency, and the bus ready line is held low during the cycle in which the read is issued. A cursor outside the frame suppresses the memory access and raises a range flag.

A separate combinational readout port turns any 8-bit pixel index into 24-bit RGB through a fixed 8-colour palette.

Top module: `fb_port`

## Requirements
- R1: After reset, both cursors read back as zero, and refresh_o, oor_o, mem_we_o and mem_re_o are low.
- R2: Register select 0 is the row cursor and select 1 is the column cursor. A bus write stores all 16 data bits, and a read returns the stored value in the same cycle.
- R3: A write to select 2 with the cursor in range asserts mem_we_o in that cycle. In that cycle mem_addr_o is row*320+column, mem_wdata_o is the low 8 bits of the bus data, and the bus is ready.
- R4: A read of select 2 with the cursor in range asserts mem_re_o for one cycle with the same address, and ready is low in that cycle. In the next cycle ready is high, and the read data is the memory byte zero-extended to 16 bits.
- R5: A select-2 access is suppressed when row >= 240 or column >= 320. Suppressed means no mem_we_o or mem_re_o, ready in the same cycle, and a read value of 0.
- R6: After a select-2 access, oor_o reports whether that access was out of range. It is 1 after a suppressed access and 0 after an in-range one, and it holds until the next select-2 access.
- R7: A write to select 3 makes refresh_o high for exactly the following cycle. A read of select 3 returns 0 and produces no pulse.
- R8: pal_rgb_o carries red on bits 23:16, green on 15:8 and blue on 7:0. The palette maps index 0 to 000000, index 1 to 7F0000, index 2 to 007F00 and index 3 to 00007F. Index 4 maps to FF0000, index 5 to 00FF00, index 6 to 0000FF, index 7 to FFFFFF, and every index from 8 to 255 to 000000.
- R9: mem_we_o and mem_re_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access request, held until ready |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid when ready |
| bus_ready_o | output | 1 | Access completes in this cycle |
| mem_addr_o | output | 17 | Linear pixel address |
| mem_we_o | output | 1 | Pixel memory write strobe |
| mem_re_o | output | 1 | Pixel memory read strobe |
| mem_wdata_o | output | 8 | Pixel write value |
| mem_rdata_i | input | 8 | Pixel read value, one cycle after mem_re_o |
| refresh_o | output | 1 | One-cycle display refresh pulse |
| oor_o | output | 1 | Last pixel access was out of range |
| pal_idx_i | input | 8 | Palette lookup index |
| pal_rgb_o | output | 24 | Palette colour |

## Verification
The palette readout runs independently of the bus. It can therefore be asked for a colour in the same cycle in which a pixel read waits on memory. The bench sets a palette index before an in-range pixel read and samples pal_rgb_o in the wait cycle. It then compares both that colour and the returned pixel against values computed from the palette rule and the memory model. The bench also issues a refresh write directly after a suppressed pixel access, and checks that the pulse arrives while the range flag stays set.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic [1:0] {
    SEL_ROW  = 2'd0,
    SEL_COL  = 2'd1,
    SEL_PIX  = 2'd2,
    SEL_SHOW = 2'd3
  } reg_sel_e;

  typedef enum logic {
    PX_IDLE,
    PX_WAIT
  } px_state_e;

  localparam logic [7:0] LVL_HALF = 8'd127;
  localparam logic [7:0] LVL_FULL = 8'd255;
endpackage

// File: rtl/fb_cursor.sv
module fb_cursor #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_row_i,
  input  logic              wr_col_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] row_o,
  output logic [DATA_W-1:0] col_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o <= '0;
      col_o <= '0;
    end else begin
      if (wr_row_i) row_o <= wdata_i;
      if (wr_col_i) col_o <= wdata_i;
    end
  end
endmodule

// File: rtl/fb_pixel_path.sv
module fb_pixel_path
  import fb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PIX_W  = 8,
  parameter int COLS   = 320,
  parameter int ROWS   = 240,
  parameter int ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              sel_pix_i,
  input  logic [PIX_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0] row_i,
  input  logic [DATA_W-1:0] col_i,
  input  logic [PIX_W-1:0]  mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [PIX_W-1:0]  mem_wdata_o,
  output logic              idle_o,
  output logic              stall_o,
  output logic              rvalid_o,
  output logic [PIX_W-1:0]  rdata_o,
  output logic              oor_o
);
  px_state_e state_q, state_d;
  logic      in_range, access;

  assign in_range = (row_i < DATA_W'(ROWS)) && (col_i < DATA_W'(COLS));
  assign idle_o   = (state_q == PX_IDLE);
  assign access   = req_i && sel_pix_i && idle_o;

  assign mem_addr_o  = ADDR_W'(row_i) * ADDR_W'(COLS) + ADDR_W'(col_i);
  assign mem_we_o    = access && we_i && in_range;
  assign mem_re_o    = access && !we_i && in_range;
  assign mem_wdata_o = wdata_i;

  assign stall_o  = mem_re_o;
  assign rvalid_o = (state_q == PX_WAIT);
  assign rdata_o  = mem_rdata_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PX_IDLE: if (mem_re_o) state_d = PX_WAIT;
      PX_WAIT: state_d = PX_IDLE;
      default: state_d = PX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PX_IDLE;
      oor_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (access) oor_o <= !in_range;
    end
  end
endmodule

// File: rtl/fb_palette.sv
module fb_palette
  import fb_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int CH_W  = 8
) (
  input  logic [PIX_W-1:0]  idx_i,
  output logic [3*CH_W-1:0] rgb_o
);
  // channel 0 = red (top byte), 1 = green, 2 = blue
  for (genvar ch = 0; ch < 3; ch++) begin : g_ch
    logic dim, bright;
    assign dim    = (idx_i == PIX_W'(1 + ch));
    assign bright = (idx_i == PIX_W'(4 + ch)) || (idx_i == PIX_W'(7));
    assign rgb_o[(2-ch)*CH_W +: CH_W] = bright ? CH_W'(LVL_FULL) :
                                        dim    ? CH_W'(LVL_HALF) : '0;
  end
endmodule

// File: rtl/fb_port.sv
module fb_port
  import fb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PIX_W  = 8,
  parameter int COLS   = 320,
  parameter int ROWS   = 240,
  localparam int ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_ready_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [PIX_W-1:0]  mem_wdata_o,
  input  logic [PIX_W-1:0]  mem_rdata_i,
  output logic              refresh_o,
  output logic              oor_o,
  input  logic [PIX_W-1:0]  pal_idx_i,
  output logic [23:0]       pal_rgb_o
);
  reg_sel_e          sel;
  logic              idle, stall, rvalid, wr;
  logic [PIX_W-1:0]  pix_rdata;
  logic [DATA_W-1:0] row_q, col_q;

  assign sel = reg_sel_e'(bus_addr_i);
  assign wr  = bus_req_i && bus_we_i && idle;

  fb_cursor #(.DATA_W(DATA_W)) u_cursor (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_row_i (wr && sel == SEL_ROW),
    .wr_col_i (wr && sel == SEL_COL),
    .wdata_i  (bus_wdata_i),
    .row_o    (row_q),
    .col_o    (col_q)
  );

  fb_pixel_path #(
    .DATA_W(DATA_W), .PIX_W(PIX_W), .COLS(COLS), .ROWS(ROWS), .ADDR_W(ADDR_W)
  ) u_pix (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (bus_req_i),
    .we_i        (bus_we_i),
    .sel_pix_i   (sel == SEL_PIX),
    .wdata_i     (bus_wdata_i[PIX_W-1:0]),
    .row_i       (row_q),
    .col_i       (col_q),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_wdata_o (mem_wdata_o),
    .idle_o      (idle),
    .stall_o     (stall),
    .rvalid_o    (rvalid),
    .rdata_o     (pix_rdata),
    .oor_o       (oor_o)
  );

  fb_palette #(.PIX_W(PIX_W), .CH_W(8)) u_pal (
    .idx_i (pal_idx_i),
    .rgb_o (pal_rgb_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) refresh_o <= 1'b0;
    else         refresh_o <= wr && (sel == SEL_SHOW);
  end

  assign bus_ready_o = !stall;

  always_comb begin
    bus_rdata_o = '0;
    if (rvalid) bus_rdata_o = DATA_W'(pix_rdata);
    else begin
      case (sel)
        SEL_ROW: bus_rdata_o = row_q;
        SEL_COL: bus_rdata_o = col_q;
        default: bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/fb_port_chk.sv
module fb_port_chk #(
  parameter int DATA_W = 16,
  parameter int PIX_W  = 8,
  parameter int COLS   = 320,
  parameter int ROWS   = 240
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [1:0]        bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              bus_ready_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [PIX_W-1:0]  mem_wdata_o,
  input logic              refresh_o,
  input logic [DATA_W-1:0] row_i,
  input logic [DATA_W-1:0] col_i
);
  a_r2_row_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && bus_we_i && bus_addr_i == 2'd0 && bus_ready_o |=> row_i == $past(bus_wdata_i));

  a_r3_wdata_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o == bus_wdata_i[PIX_W-1:0] && bus_ready_o);

  a_r4_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> !bus_ready_o);

  a_r4_ready_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> bus_ready_o && !mem_re_o);

  a_r5_suppress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && bus_addr_i == 2'd2 && (row_i >= DATA_W'(ROWS) || col_i >= DATA_W'(COLS))
    |-> !mem_we_o && !mem_re_o && bus_ready_o);

  a_r7_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |-> $past(bus_req_i && bus_we_i && bus_addr_i == 2'd3));

  a_r9_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
endmodule

bind fb_port fb_port_chk #(
  .DATA_W(DATA_W), .PIX_W(PIX_W), .COLS(COLS), .ROWS(ROWS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_ready_o (bus_ready_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .mem_wdata_o (mem_wdata_o),
  .refresh_o   (refresh_o),
  .row_i       (row_q),
  .col_i       (col_q)
);

// File: tb/tb_fb_port.sv
`timescale 1ns/1ps
module tb_fb_port;
  localparam int COLS = 320;
  localparam int ROWS = 240;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ready;
  logic [16:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        refresh, oor;
  logic [7:0]  pal_idx = '0;
  logic [23:0] pal_rgb;

  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  fb_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_ready_o(ready),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .refresh_o(refresh), .oor_o(oor),
    .pal_idx_i(pal_idx), .pal_rgb_o(pal_rgb)
  );

  logic [7:0] mem_model [int];

  function automatic logic [7:0] model_rd(int a);
    if (mem_model.exists(a)) return mem_model[a];
    return 8'(a) ^ 8'h5A;
  endfunction

  always @(posedge clk_i) begin
    if (mem_we) mem_model[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= model_rd(int'(mem_addr));
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // snapshot of the access cycle
  logic        s_we, s_re, s_rdy, s_rdy2;
  logic [16:0] s_addr;
  logic [7:0]  s_wd;
  logic [23:0] s_rgb;

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    #1;
    s_we = mem_we; s_re = mem_re; s_rdy = ready; s_addr = mem_addr; s_wd = mem_wdata;
    @(posedge clk_i); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk_i);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    s_we = mem_we; s_re = mem_re; s_rdy = ready; s_addr = mem_addr; s_rdy2 = 1'b1;
    if (!ready) begin
      @(negedge clk_i); #1;
      s_rdy2 = ready;
      s_rgb = pal_rgb;
    end
    d = rdata;
    @(posedge clk_i); #1;
    req = 1'b0;
  endtask

  function automatic logic [23:0] exp_rgb(int i);
    logic [7:0] r, g, b;
    r = (i == 1) ? 8'd127 : (i == 4 || i == 7) ? 8'd255 : 8'd0;
    g = (i == 2) ? 8'd127 : (i == 5 || i == 7) ? 8'd255 : 8'd0;
    b = (i == 3) ? 8'd127 : (i == 6 || i == 7) ? 8'd255 : 8'd0;
    return {r, g, b};
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int rl[4] = '{0, 1, 120, 239};
    int cl[3] = '{0, 1, 319};

    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 refresh", refresh, 0);
    chk("R1 oor", oor, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 mem_re", mem_re, 0);
    rst_ni = 1'b1;
    bus_rd(2'd0, d); chk("R1 row reset", d, 0);
    bus_rd(2'd1, d); chk("R1 col reset", d, 0);

    // R2 cursor registers, full width
    bus_wr(2'd0, 16'hBEEF); chk("R2 write ready", s_rdy, 1);
    bus_wr(2'd1, 16'h1234);
    bus_rd(2'd0, d); chk("R2 row", d, 16'hBEEF); chk("R2 read ready", s_rdy, 1);
    bus_rd(2'd1, d); chk("R2 col", d, 16'h1234);

    // R3 pixel writes over corners and interior
    foreach (rl[i]) foreach (cl[j]) begin
      logic [7:0] v;
      v = 8'(rl[i] * 7 + cl[j] * 3 + 1);
      bus_wr(2'd0, 16'(rl[i]));
      bus_wr(2'd1, 16'(cl[j]));
      bus_wr(2'd2, {8'hA5, v});
      chk("R3 we", s_we, 1);
      chk("R9 re low on write", s_re, 0);
      chk("R3 addr", 32'(s_addr), 32'(rl[i] * COLS + cl[j]));
      chk("R3 wdata", s_wd, v);
      chk("R3 ready", s_rdy, 1);
      chk("R6 oor clear", oor, 0);
    end

    // R4 pixel reads back
    foreach (rl[i]) foreach (cl[j]) begin
      bus_wr(2'd0, 16'(rl[i]));
      bus_wr(2'd1, 16'(cl[j]));
      bus_rd(2'd2, d);
      chk("R4 re", s_re, 1);
      chk("R4 stall", s_rdy, 0);
      chk("R4 addr", 32'(s_addr), 32'(rl[i] * COLS + cl[j]));
      chk("R4 ready next", s_rdy2, 1);
      chk("R4 data", d, {8'h00, 8'(rl[i] * 7 + cl[j] * 3 + 1)});
    end

    // R4 untouched location, concurrent with palette readout
    pal_idx = 8'd5;
    bus_wr(2'd0, 16'd200); bus_wr(2'd1, 16'd100);
    bus_rd(2'd2, d);
    chk("R4 model data", d, {8'h00, 8'(200 * COLS + 100) ^ 8'h5A});
    chk("R8 palette during wait", s_rgb, 24'h00FF00);

    // R5/R6 out of range: row 240, column 320, row FFFF
    bus_wr(2'd0, 16'd240); bus_wr(2'd1, 16'd0);
    bus_wr(2'd2, 16'h0033);
    chk("R5 no we row240", s_we, 0); chk("R5 ready", s_rdy, 1);
    chk("R6 oor set", oor, 1);
    bus_rd(2'd2, d);
    chk("R5 no re row240", s_re, 0); chk("R5 read zero", d, 0);
    chk("R5 read ready", s_rdy, 1);
    // R7 refresh right after suppressed access; flag must hold
    bus_wr(2'd3, 16'hFFFF);
    chk("R7 pulse", refresh, 1);
    chk("R6 oor held", oor, 1);
    @(posedge clk_i); #1;
    chk("R7 pulse one cycle", refresh, 0);
    bus_rd(2'd3, d);
    chk("R7 read zero", d, 0);
    chk("R7 no pulse on read", refresh, 0);

    bus_wr(2'd0, 16'd0); bus_wr(2'd1, 16'd320);
    bus_rd(2'd2, d);
    chk("R5 no re col320", s_re, 0); chk("R5 col320 zero", d, 0);
    bus_wr(2'd2, 16'h0077); chk("R5 no we col320", s_we, 0);
    bus_wr(2'd0, 16'hFFFF); bus_wr(2'd1, 16'd5);
    bus_wr(2'd2, 16'h0011); chk("R5 no we rowFFFF", s_we, 0);
    chk("R6 oor still", oor, 1);
    bus_wr(2'd0, 16'd0); bus_wr(2'd1, 16'd0);
    bus_rd(2'd2, d);
    chk("R5 earlier write ignored", d, {8'h00, 8'd1});
    chk("R6 oor cleared by read", oor, 0);

    // R8 full palette sweep
    for (int i = 0; i < 256; i++) begin
      pal_idx = 8'(i);
      #1;
      chk("R8 palette", pal_rgb, exp_rgb(i));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule